// File: doc/BRIEF.md
# USB Control Endpoint Handshake Sequencer

This block chooses, for every token seen on one device endpoint, which handshake the endpoint returns. The choice depends on a 4-bit mode that firmware programs. The token's type, its received byte count, a CRC-good flag and the received data toggle come from the serial engine that sits upstream of this block. The block registers its answer as a response code together with a one-cycle interrupt. On the same edge it updates the endpoint status: the Setup, In, Out and Acknowledge flags, a data-valid bit, the last toggle and the last byte count.

Once a packet has been accepted, the mode advances by itself through a control transfer. A good SETUP moves the endpoint into a NAK-everything mode until firmware has had time to look at the packet. A good data OUT in control-write mode moves it to a mode that NAKs further OUTs and completes the status stage. A status OUT that comes too early, or a protocol violation, moves it to a STALL mode.

Firmware reaches the mode and the four flags through one 8-bit read/write port. Every transaction that raises an interrupt locks that register against firmware writes, and a firmware read releases the lock. The Setup flag can always be written, even while the rest of the register is locked.

Top module: `usb_ep_ctrl`

## Requirements
- R1: After reset the mode register reads 0x00, the response is 0, there is no interrupt, the register is unlocked, and data-valid, toggle and count are all 0.
- R2: Token code 0 (SETUP) is taken in every mode. When it has good CRC and a count of 10 or less, the block answers 1 (ACK), sets the Setup and Acknowledge flags, sets data-valid, loads the toggle and the count, changes the mode to 0001 and raises the interrupt.
- R3: A SETUP with bad CRC or a count above 10 gets response 0. It sets the Setup flag, clears data-valid, loads the toggle and the count, leaves the mode as it was and raises the interrupt.
- R4: In modes 0000, 0100 and every mode not named in R5 to R9, IN (code 1) and OUT (code 2) tokens get response 0, change no state and raise no interrupt.
- R5: Mode 0001 answers IN and OUT with 2 (NAK). Mode 0011 answers them with 3 (STALL). In both modes the In or Out flag that matches the token is set and the interrupt is raised.
- R6: In mode 1011 every OUT sets the Out flag, loads the toggle and the count, and raises the interrupt. If the OUT has good CRC and a count of 10 or less, it also sets data-valid and the Acknowledge flag, answers ACK and moves the mode to 1010. Otherwise it clears data-valid and gets response 0.
- R7: In modes 1011, 1010 and 0110 an IN is answered with 4 (zero-length data), sets the In and Acknowledge flags and raises the interrupt. In mode 1010 an OUT with good CRC and a count of 10 or less gets NAK, sets the Out flag and raises the interrupt. Any other OUT in mode 1010 is ignored with no state change.
- R8: In mode 0110 an OUT with good CRC and a count of 10 or less gets STALL, sets the Out flag, raises the interrupt and moves the mode to 0011. Any other OUT is ignored with no state change.
- R9: In modes 1111 and 1110, an OUT with good CRC, a count of 10 or less and a count of exactly 2 with toggle 1 gets ACK and sets the Out and Acknowledge flags. A good OUT that fails the count-or-toggle test gets STALL, sets the Out flag and moves the mode to 0011. Both of these set data-valid and load the toggle and the count, and any other OUT is ignored. An IN in mode 1111 gets ACK, sets the In and Acknowledge flags and moves the mode to 1110. An IN in mode 1110 gets NAK and sets the In flag.
- R10: The interrupt and a non-zero response last exactly one cycle, in the cycle after the token strobe.
- R11: The register layout is bit 7 Setup, bit 6 In, bit 5 Out, bit 4 Acknowledge, bits 3:0 mode. Any token that raises the interrupt sets the lock. While the lock is set, a firmware write changes only bit 7. A firmware read clears the lock.
- R12: A firmware write in the same cycle as a token that raises the interrupt changes only bit 7, and the lock is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tok_valid_i | input | 1 | One-cycle strobe for a finished token |
| tok_kind_i | input | 2 | Token type: 0 SETUP, 1 IN, 2 OUT |
| rx_cnt_i | input | CNT_W | Received byte count |
| rx_crc_ok_i | input | 1 | Received packet has good CRC |
| rx_tog_i | input | 1 | Received data toggle |
| fw_wr_i | input | 1 | Firmware write strobe for the mode register |
| fw_wdata_i | input | 8 | Firmware write data |
| fw_rd_i | input | 1 | Firmware read strobe; clears the lock |
| fw_rdata_o | output | 8 | Mode register contents |
| resp_o | output | 3 | Response: 0 none, 1 ACK, 2 NAK, 3 STALL, 4 zero-length data |
| irq_o | output | 1 | Interrupt pulse |
| locked_o | output | 1 | Mode register is locked against firmware writes |
| dval_o | output | 1 | Data-valid flag |
| tog_o | output | 1 | Last received toggle |
| cnt_o | output | CNT_W | Last received byte count |

## Verification
The assertions assume that token strobes never arrive on two consecutive cycles and that the token type is never the reserved code 3. The bench keeps to this by leaving at least one idle cycle after every strobe and by driving only SETUP, IN and OUT. Each sweep trial first reads the register and then writes the mode before it sends the token, so every trial starts unlocked with all flags clear. The toggle, count and data-valid values carried over from earlier trials are tracked in the bench.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

    localparam logic [1:0] TK_SETUP = 2'd0;
    localparam logic [1:0] TK_IN    = 2'd1;
    localparam logic [1:0] TK_OUT   = 2'd2;

    localparam logic [2:0] RSP_NONE  = 3'd0;
    localparam logic [2:0] RSP_ACK   = 3'd1;
    localparam logic [2:0] RSP_NAK   = 3'd2;
    localparam logic [2:0] RSP_STALL = 3'd3;
    localparam logic [2:0] RSP_ZLEN  = 3'd4;

    localparam logic [3:0] M_OFF     = 4'b0000;
    localparam logic [3:0] M_NAK     = 4'b0001;
    localparam logic [3:0] M_STALL   = 4'b0011;
    localparam logic [3:0] M_SKIP    = 4'b0100;
    localparam logic [3:0] M_STAT_IN = 4'b0110;
    localparam logic [3:0] M_CW_NAK  = 4'b1010;
    localparam logic [3:0] M_CW      = 4'b1011;
    localparam logic [3:0] M_CR_NAK  = 4'b1110;
    localparam logic [3:0] M_CR      = 4'b1111;

    typedef struct packed {
        logic [2:0] resp;
        logic       irq;
        logic       set_setup;
        logic       set_in;
        logic       set_out;
        logic       set_ack;
        logic       load_cnt;
        logic       load_tog;
        logic       load_dval;
        logic       dval_val;
        logic       load_mode;
        logic [3:0] mode_nx;
    } ep_act_t;

endpackage

// File: rtl/ep_token_decide.sv
module ep_token_decide
    import usb_ep_pkg::*;
#(
    parameter int CNT_W    = 7,
    parameter int CTRL_MAX = 10,
    parameter int STAT_LEN = 2
) (
    input  logic [3:0]       mode_i,
    input  logic [1:0]       tok_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             crc_ok_i,
    input  logic             tog_i,
    output ep_act_t          act_o
);

    localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(CTRL_MAX);
    localparam logic [CNT_W-1:0] STAT_C = CNT_W'(STAT_LEN);

    logic    good;
    logic    is_in;
    logic    is_out;
    ep_act_t a;

    assign good   = (cnt_i <= MAX_C) && crc_ok_i;
    assign is_in  = (tok_i == TK_IN);
    assign is_out = (tok_i == TK_OUT);

    always_comb begin
        a         = '0;
        a.resp    = RSP_NONE;
        a.mode_nx = mode_i;
        if (tok_i == TK_SETUP) begin
            a.irq       = 1'b1;
            a.set_setup = 1'b1;
            a.load_cnt  = 1'b1;
            a.load_tog  = 1'b1;
            a.load_dval = 1'b1;
            if (good) begin
                a.dval_val  = 1'b1;
                a.set_ack   = 1'b1;
                a.resp      = RSP_ACK;
                a.load_mode = 1'b1;
                a.mode_nx   = M_NAK;
            end
        end else if (is_in || is_out) begin
            case (mode_i)
                M_NAK, M_STALL: begin
                    a.irq     = 1'b1;
                    a.set_in  = is_in;
                    a.set_out = is_out;
                    a.resp    = (mode_i == M_NAK) ? RSP_NAK : RSP_STALL;
                end
                M_CW, M_CW_NAK, M_STAT_IN: begin
                    if (is_in) begin
                        a.irq     = 1'b1;
                        a.set_in  = 1'b1;
                        a.set_ack = 1'b1;
                        a.resp    = RSP_ZLEN;
                    end else if (mode_i == M_CW) begin
                        a.irq       = 1'b1;
                        a.set_out   = 1'b1;
                        a.load_cnt  = 1'b1;
                        a.load_tog  = 1'b1;
                        a.load_dval = 1'b1;
                        a.dval_val  = good;
                        if (good) begin
                            a.set_ack   = 1'b1;
                            a.resp      = RSP_ACK;
                            a.load_mode = 1'b1;
                            a.mode_nx   = M_CW_NAK;
                        end
                    end else if (good) begin
                        a.irq     = 1'b1;
                        a.set_out = 1'b1;
                        if (mode_i == M_CW_NAK) begin
                            a.resp = RSP_NAK;
                        end else begin
                            a.resp      = RSP_STALL;
                            a.load_mode = 1'b1;
                            a.mode_nx   = M_STALL;
                        end
                    end
                end
                M_CR, M_CR_NAK: begin
                    if (is_in) begin
                        a.irq    = 1'b1;
                        a.set_in = 1'b1;
                        if (mode_i == M_CR) begin
                            a.set_ack   = 1'b1;
                            a.resp      = RSP_ACK;
                            a.load_mode = 1'b1;
                            a.mode_nx   = M_CR_NAK;
                        end else begin
                            a.resp = RSP_NAK;
                        end
                    end else if (good) begin
                        a.irq       = 1'b1;
                        a.set_out   = 1'b1;
                        a.load_cnt  = 1'b1;
                        a.load_tog  = 1'b1;
                        a.load_dval = 1'b1;
                        a.dval_val  = 1'b1;
                        if ((cnt_i == STAT_C) && tog_i) begin
                            a.set_ack = 1'b1;
                            a.resp    = RSP_ACK;
                        end else begin
                            a.resp      = RSP_STALL;
                            a.load_mode = 1'b1;
                            a.mode_nx   = M_STALL;
                        end
                    end
                end
                default: begin
                    a.resp = RSP_NONE;
                end
            endcase
        end
    end

    assign act_o = a;

endmodule

// File: rtl/ep_lock_ctrl.sv
module ep_lock_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    input  logic commit_i,
    output logic locked_o
);

    logic lock_d;
    logic lock_q;

    always_comb begin
        lock_d = lock_q;
        if (rd_i) begin
            lock_d = 1'b0;
        end
        if (commit_i) begin
            lock_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else begin
            lock_q <= lock_d;
        end
    end

    assign locked_o = lock_q;

    // R11
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !commit_i) |=> !locked_o);

endmodule

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl
    import usb_ep_pkg::*;
#(
    parameter int CNT_W    = 7,
    parameter int CTRL_MAX = 10,
    parameter int STAT_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid_i,
    input  logic [1:0]       tok_kind_i,
    input  logic [CNT_W-1:0] rx_cnt_i,
    input  logic             rx_crc_ok_i,
    input  logic             rx_tog_i,
    input  logic             fw_wr_i,
    input  logic [7:0]       fw_wdata_i,
    input  logic             fw_rd_i,
    output logic [7:0]       fw_rdata_o,
    output logic [2:0]       resp_o,
    output logic             irq_o,
    output logic             locked_o,
    output logic             dval_o,
    output logic             tog_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(CTRL_MAX);
    localparam logic [CNT_W-1:0] STAT_C = CNT_W'(STAT_LEN);

    typedef struct packed {
        logic [3:0]       mode;
        logic             f_setup;
        logic             f_in;
        logic             f_out;
        logic             f_ack;
        logic             dval;
        logic             tog;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       resp;
        logic             irq;
    } ep_state_t;

    ep_state_t s_d;
    ep_state_t s_q;
    ep_act_t   act;
    logic      commit;
    logic      locked;

    ep_token_decide #(
        .CNT_W   (CNT_W),
        .CTRL_MAX(CTRL_MAX),
        .STAT_LEN(STAT_LEN)
    ) u_decide (
        .mode_i  (s_q.mode),
        .tok_i   (tok_kind_i),
        .cnt_i   (rx_cnt_i),
        .crc_ok_i(rx_crc_ok_i),
        .tog_i   (rx_tog_i),
        .act_o   (act)
    );

    assign commit = tok_valid_i && act.irq;

    ep_lock_ctrl u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (fw_rd_i),
        .commit_i(commit),
        .locked_o(locked)
    );

    always_comb begin
        s_d      = s_q;
        s_d.resp = RSP_NONE;
        s_d.irq  = 1'b0;
        if (fw_wr_i) begin
            s_d.f_setup = fw_wdata_i[7];
            if (!locked && !commit) begin
                s_d.f_in  = fw_wdata_i[6];
                s_d.f_out = fw_wdata_i[5];
                s_d.f_ack = fw_wdata_i[4];
                s_d.mode  = fw_wdata_i[3:0];
            end
        end
        if (commit) begin
            s_d.irq  = 1'b1;
            s_d.resp = act.resp;
            if (act.set_setup) s_d.f_setup = 1'b1;
            if (act.set_in)    s_d.f_in    = 1'b1;
            if (act.set_out)   s_d.f_out   = 1'b1;
            if (act.set_ack)   s_d.f_ack   = 1'b1;
            if (act.load_cnt)  s_d.cnt     = rx_cnt_i;
            if (act.load_tog)  s_d.tog     = rx_tog_i;
            if (act.load_dval) s_d.dval    = act.dval_val;
            if (act.load_mode) s_d.mode    = act.mode_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fw_rdata_o = {s_q.f_setup, s_q.f_in, s_q.f_out, s_q.f_ack, s_q.mode};
    assign resp_o     = s_q.resp;
    assign irq_o      = s_q.irq;
    assign locked_o   = locked;
    assign dval_o     = s_q.dval;
    assign tog_o      = s_q.tog;
    assign cnt_o      = s_q.cnt;

    // R2
    setup_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid_i && tok_kind_i == TK_SETUP && rx_crc_ok_i && rx_cnt_i <= MAX_C)
        |=> (fw_rdata_o[3:0] == M_NAK && resp_o == RSP_ACK && irq_o && dval_o));

    // R4
    idle_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid_i && tok_kind_i != TK_SETUP && !fw_wr_i &&
         (fw_rdata_o[3:0] == M_OFF || fw_rdata_o[3:0] == M_SKIP))
        |=> (!irq_o && $stable(fw_rdata_o) && $stable(cnt_o)));

    // R9
    ctrl_read_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid_i && tok_kind_i == TK_OUT && fw_rdata_o[3:0] == M_CR && !fw_wr_i &&
         rx_crc_ok_i && rx_cnt_i == STAT_C && rx_tog_i)
        |=> (resp_o == RSP_ACK && $stable(fw_rdata_o[3:0])));

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R10
    resp_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_o != RSP_NONE) |-> irq_o);

    // R11
    irq_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> locked_o);

    // R11
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && fw_wr_i && !tok_valid_i) |=> $stable(fw_rdata_o[6:0]));

endmodule

// File: tb/usb_ep_ctrl_test.sv
`timescale 1ns/1ps
module usb_ep_ctrl_test;

    localparam int CW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tok_valid = 1'b0;
    logic [1:0]    tok_kind = 2'd0;
    logic [CW-1:0] rx_cnt = '0;
    logic          rx_crc_ok = 1'b0;
    logic          rx_tog = 1'b0;
    logic          fw_wr = 1'b0;
    logic [7:0]    fw_wdata = 8'h00;
    logic          fw_rd = 1'b0;
    logic [7:0]    fw_rdata;
    logic [2:0]    resp;
    logic          irq;
    logic          locked;
    logic          dval;
    logic          tog;
    logic [CW-1:0] cnt;

    int n_chk  = 0;
    int n_fail = 0;

    // bench-side expected state
    logic [7:0]    e_reg;
    logic          e_dval = 1'b0;
    logic          e_tog = 1'b0;
    logic [CW-1:0] e_cnt = '0;
    logic [2:0]    e_resp;
    logic          e_irq;

    usb_ep_ctrl #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .tok_valid_i(tok_valid), .tok_kind_i(tok_kind),
        .rx_cnt_i(rx_cnt), .rx_crc_ok_i(rx_crc_ok), .rx_tog_i(rx_tog),
        .fw_wr_i(fw_wr), .fw_wdata_i(fw_wdata), .fw_rd_i(fw_rd),
        .fw_rdata_o(fw_rdata), .resp_o(resp), .irq_o(irq), .locked_o(locked),
        .dval_o(dval), .tog_o(tog), .cnt_o(cnt)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fw_read();
        @(negedge clk) fw_rd = 1'b1;
        @(negedge clk) fw_rd = 1'b0;
    endtask

    task automatic fw_write(input logic [7:0] v);
        @(negedge clk) begin fw_wr = 1'b1; fw_wdata = v; end
        @(negedge clk) fw_wr = 1'b0;
    endtask

    task automatic send(input logic [1:0] k, input int c, input logic crc, input logic t);
        @(negedge clk) begin
            tok_valid = 1'b1; tok_kind = k; rx_cnt = CW'(c); rx_crc_ok = crc; rx_tog = t;
        end
        @(negedge clk) tok_valid = 1'b0;
    endtask

    // expected effect of one token on e_* from the requirement text
    task automatic model(input logic [1:0] k, input int c, input logic crc, input logic t);
        logic [3:0] m;
        logic good;
        m = e_reg[3:0];
        good = crc && (c <= 10);
        e_resp = 3'd0;
        e_irq = 1'b0;
        if (k == 2'd0) begin
            e_irq = 1'b1; e_reg[7] = 1'b1; e_cnt = CW'(c); e_tog = t; e_dval = good;
            if (good) begin e_resp = 3'd1; e_reg[4] = 1'b1; e_reg[3:0] = 4'b0001; end
        end else if (m == 4'b0001 || m == 4'b0011) begin
            e_irq = 1'b1; e_resp = (m == 4'b0001) ? 3'd2 : 3'd3;
            if (k == 2'd1) e_reg[6] = 1'b1; else e_reg[5] = 1'b1;
        end else if ((m == 4'b1011 || m == 4'b1010 || m == 4'b0110) && k == 2'd1) begin
            e_irq = 1'b1; e_resp = 3'd4; e_reg[6] = 1'b1; e_reg[4] = 1'b1;
        end else if (m == 4'b1011) begin
            e_irq = 1'b1; e_reg[5] = 1'b1; e_cnt = CW'(c); e_tog = t; e_dval = good;
            if (good) begin e_resp = 3'd1; e_reg[4] = 1'b1; e_reg[3:0] = 4'b1010; end
        end else if (m == 4'b1010 && good) begin
            e_irq = 1'b1; e_resp = 3'd2; e_reg[5] = 1'b1;
        end else if (m == 4'b0110 && good) begin
            e_irq = 1'b1; e_resp = 3'd3; e_reg[5] = 1'b1; e_reg[3:0] = 4'b0011;
        end else if ((m == 4'b1111 || m == 4'b1110) && k == 2'd1) begin
            e_irq = 1'b1; e_reg[6] = 1'b1;
            if (m == 4'b1111) begin e_resp = 3'd1; e_reg[4] = 1'b1; e_reg[3:0] = 4'b1110; end
            else e_resp = 3'd2;
        end else if ((m == 4'b1111 || m == 4'b1110) && good) begin
            e_irq = 1'b1; e_reg[5] = 1'b1; e_cnt = CW'(c); e_tog = t; e_dval = 1'b1;
            if (c == 2 && t) begin e_resp = 3'd1; e_reg[4] = 1'b1; end
            else begin e_resp = 3'd3; e_reg[3:0] = 4'b0011; end
        end
    endtask

    function automatic string req_of(input logic [3:0] m, input logic [1:0] k, input int c, input logic crc);
        if (k == 2'd0) return (crc && c <= 10) ? "R2" : "R3";
        case (m)
            4'b0001, 4'b0011: return "R5";
            4'b1011: return (k == 2'd2) ? "R6" : "R7";
            4'b1010: return "R7";
            4'b0110: return (k == 2'd1) ? "R7" : "R8";
            4'b1111, 4'b1110: return "R9";
            default: return "R4";
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int cnt_set [6] = '{0, 2, 3, 10, 11, 40};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "reg", fw_rdata, 0);
        check("R1", "resp", resp, 0);
        check("R1", "irq", irq, 0);
        check("R1", "locked", locked, 0);
        check("R1", "dval/tog/cnt", {dval, tog, cnt}, 0);

        // sweep: every mode, token, count, CRC and toggle
        for (int m = 0; m < 16; m++) begin
            for (int k = 0; k < 3; k++) begin
                for (int ci = 0; ci < 6; ci++) begin
                    for (int cr = 0; cr < 2; cr++) begin
                        for (int t = 0; t < 2; t++) begin
                            string rq;
                            fw_read();
                            fw_write({4'b0000, 4'(m)});
                            e_reg = {4'b0000, 4'(m)};
                            rq = req_of(4'(m), 2'(k), cnt_set[ci], cr[0]);
                            model(2'(k), cnt_set[ci], cr[0], t[0]);
                            send(2'(k), cnt_set[ci], cr[0], t[0]);
                            check(rq, "resp", resp, e_resp);
                            check(rq, "irq", irq, e_irq);
                            check(rq, "reg", fw_rdata, e_reg);
                            check(rq, "dval", dval, e_dval);
                            check(rq, "tog", tog, e_tog);
                            check(rq, "cnt", cnt, e_cnt);
                            // R11 lock follows interrupt
                            check("R11", "locked", locked, e_irq);
                            @(negedge clk);
                            // R10 single-cycle pulse
                            check("R10", "irq after", irq, 0);
                            check("R10", "resp after", resp, 0);
                        end
                    end
                end
            end
        end

        // R11: locked write touches only bit 7, read unlocks
        fw_read();
        fw_write(8'h0B);
        send(2'd2, 8, 1'b1, 1'b0);
        check("R11", "locked after commit", locked, 1);
        check("R11", "reg after commit", fw_rdata, 8'h3A);
        fw_write(8'h83);
        check("R11", "locked write", fw_rdata, 8'hBA);
        fw_read();
        check("R11", "unlocked by read", locked, 0);
        fw_write(8'h03);
        check("R11", "write after read", fw_rdata, 8'h03);

        // R12: write in the same cycle as a committing token
        fw_read();
        fw_write(8'h0B);
        @(negedge clk) begin
            tok_valid = 1'b1; tok_kind = 2'd2; rx_cnt = CW'(4); rx_crc_ok = 1'b1; rx_tog = 1'b1;
            fw_wr = 1'b1; fw_wdata = 8'h81;
        end
        @(negedge clk) begin tok_valid = 1'b0; fw_wr = 1'b0; end
        check("R12", "reg", fw_rdata, 8'hBA);
        check("R12", "locked", locked, 1);
        check("R12", "resp", resp, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule